// File: doc/BRIEF.md
# Storage-Card Clock Source Selector

This block picks which of three clock sources feeds a storage-card host. Software programs a 2-bit source code through a small register port; the block checks each request against the allowed switching rules, holds a busy flag for a fixed settling interval, and then moves a one-hot select vector that drives an external clock mux. The three codes are 1 (fastest source, the reset choice), 2 (middle source) and 3 (slowest source). Code 0 is never applied, and a move between codes 1 and 2 must go through code 3 first.

Writes use a masked format: bits 31:16 of the write word enable the matching bits 15:0, so a field bit changes only when its enable bit is set. Illegal requests, and any select write that arrives while a switch is still settling, leave the source untouched and raise a sticky error flag that software clears through the status register.

The control is a two-state machine. In state IDLE the block accepts requests; a legal request (transition GO) loads a cycle counter and enters state SWITCH. In SWITCH the counter runs down; when it reaches zero (transition DONE) the pending code becomes the applied code and the machine returns to IDLE. All other cases (no write, a write asking for the current code, an illegal write, a write during SWITCH) keep the state where it is.

Top module: `sd_clk_src_sel`

## Requirements
- R1: After reset the applied code is 1, `sel_onehot` is 3'b001, `busy` is 0 and the error flag is 0.
- R2: `sel_onehot` bit 0, 1 or 2 is the only bit set when the applied code is 1, 2 or 3 respectively; a read with `rd_addr`=0 returns the applied code in bits 1:0 and zero in bits 31:2.
- R3: A write with `wr_addr`=0 forms the requested code bit by bit: bit i comes from `wr_data[i]` when `wr_data[i+16]` is 1 and from the applied code otherwise; a request equal to the applied code does nothing and raises no error.
- R4: A request for code 0 is not applied and sets the error flag.
- R5: A request from code 1 to code 2 or from code 2 to code 1 is not applied and sets the error flag; the applied code only ever changes to or from code 3.
- R6: A legal request sampled at clock edge k sets `busy` from edge k for exactly SWITCH_CYCLES cycles; the applied code and `sel_onehot` change at the edge where `busy` falls, and never otherwise.
- R7: A write with `wr_addr`=0 sampled while `busy` is 1, including its last cycle, is rejected, sets the error flag and does not alter the running switch.
- R8: A read with `rd_addr`=1 returns `busy` in bit 0 and the error flag in bit 1, zeros elsewhere; the flag stays set until a write with `wr_addr`=1 has both bit 1 and bit 17 set, and a status write lacking bit 17 leaves it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 select, 1 status |
| wr_data | input | 32 | Write word: enables in 31:16, values in 15:0 |
| rd_addr | input | 1 | Read target: 0 select, 1 status |
| rd_data | output | 32 | Combinational read data |
| sel_onehot | output | 3 | One-hot source select for the clock mux |
| busy | output | 1 | High while a switch is settling |

## Verification
The collision that matters is a new select write landing on the final settling cycle, the same edge at which the pending code is applied and `busy` drops. The bench times a write so that it is sampled exactly on that edge and expects the switch to complete while the write is rejected with the error flag set, then repeats the write one cycle later and expects it to be accepted. A behavioural reference model tracks code, busy count and error flag from the port activity and is compared against the outputs and both read addresses on every cycle.

// File: rtl/sdsel_pkg.sv
package sdsel_pkg;

    localparam int CODE_W = 2;

    localparam logic [CODE_W-1:0] CODE_OFF  = 2'd0;
    localparam logic [CODE_W-1:0] CODE_FAST = 2'd1;
    localparam logic [CODE_W-1:0] CODE_MID  = 2'd2;
    localparam logic [CODE_W-1:0] CODE_SLOW = 2'd3;

    typedef enum logic {
        ST_IDLE,
        ST_SWITCH
    } sw_state_e;

    typedef enum logic [1:0] {
        VERD_NOP,
        VERD_GO,
        VERD_BAD
    } verdict_e;

    function automatic logic step_allowed(input logic [CODE_W-1:0] from_code,
                                          input logic [CODE_W-1:0] to_code);
        logic direct;
        direct = ((from_code == CODE_FAST) && (to_code == CODE_MID)) ||
                 ((from_code == CODE_MID)  && (to_code == CODE_FAST));
        return (to_code != CODE_OFF) && !direct;
    endfunction

endpackage

// File: rtl/sdsel_screen.sv
module sdsel_screen
    import sdsel_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                sel_wr,
    input  logic                busy,
    input  logic [CODE_W-1:0]   cur_code,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [CODE_W-1:0]   req_code,
    output verdict_e            verdict
);
    localparam int MASK_OFS = DATA_W / 2;

    // per-bit masked merge of the request with the applied code
    for (genvar i = 0; i < CODE_W; i++) begin : g_merge
        assign req_code[i] = wr_data[MASK_OFS + i] ? wr_data[i] : cur_code[i];
    end

    always_comb begin
        if (!sel_wr) begin
            verdict = VERD_NOP;
        end else if (busy) begin
            verdict = VERD_BAD;
        end else if (req_code == cur_code) begin
            verdict = VERD_NOP;
        end else if (!step_allowed(cur_code, req_code)) begin
            verdict = VERD_BAD;
        end else begin
            verdict = VERD_GO;
        end
    end

endmodule

// File: rtl/sdsel_ctrl.sv
module sdsel_ctrl
    import sdsel_pkg::*;
#(
    parameter int SWITCH_CYCLES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  verdict_e            verdict,
    input  logic [CODE_W-1:0]   req_code,
    output logic [CODE_W-1:0]   code,
    output logic                busy
);
    localparam int CNT_W = (SWITCH_CYCLES > 1) ? $clog2(SWITCH_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SWITCH_CYCLES - 1);

    sw_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [CODE_W-1:0] pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            code  <= CODE_FAST;
            pend  <= CODE_FAST;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (verdict == VERD_GO) begin
                        state <= ST_SWITCH;
                        cnt   <= CNT_LOAD;
                        pend  <= req_code;
                    end
                end
                ST_SWITCH: begin
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                        code  <= pend;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy = (state == ST_SWITCH);
    end

    // R6: the applied code moves only at the end of a settling interval
    a_r6_change_needs_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (code != $past(code)) |-> $past(state == ST_SWITCH));

    // R4: code 0 is never applied
    a_r4_never_off: assert property (@(posedge clk) disable iff (!rst_n)
        code != CODE_OFF);

    // R5: every applied change touches the slowest source
    a_r5_via_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (code != $past(code)) |-> ((code == CODE_SLOW) || ($past(code) == CODE_SLOW)));

    // R7: a running switch is not restarted by a fresh request
    a_r7_pend_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state == ST_SWITCH) && (state == ST_SWITCH)) |-> $stable(pend));

    // R6: counter never exceeds its load value
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LOAD);

endmodule

// File: rtl/sdsel_err.sv
module sdsel_err
    import sdsel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  verdict_e verdict,
    input  logic     clr,
    output logic     err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (verdict == VERD_BAD) begin
            err <= 1'b1;
        end else if (clr) begin
            err <= 1'b0;
        end
    end

    // R8: without a clear the flag cannot fall
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err) && !$past(clr)) |-> err);

endmodule

// File: rtl/sd_clk_src_sel.sv
module sd_clk_src_sel
    import sdsel_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int NUM_SRC       = 3,
    parameter int SWITCH_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_SRC-1:0] sel_onehot,
    output logic              busy
);
    localparam int MASK_OFS = DATA_W / 2;
    localparam int ERR_BIT  = 1;

    logic              sel_wr;
    logic              clr_err;
    logic [CODE_W-1:0] req_code;
    logic [CODE_W-1:0] code;
    logic              err;
    verdict_e          verdict;

    assign sel_wr  = wr_en && (wr_addr == 1'b0);
    assign clr_err = wr_en && (wr_addr == 1'b1) &&
                     wr_data[ERR_BIT] && wr_data[MASK_OFS + ERR_BIT];

    sdsel_screen #(.DATA_W(DATA_W)) u_screen (
        .sel_wr   (sel_wr),
        .busy     (busy),
        .cur_code (code),
        .wr_data  (wr_data),
        .req_code (req_code),
        .verdict  (verdict)
    );

    sdsel_ctrl #(.SWITCH_CYCLES(SWITCH_CYCLES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .verdict  (verdict),
        .req_code (req_code),
        .code     (code),
        .busy     (busy)
    );

    sdsel_err u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .verdict (verdict),
        .clr     (clr_err),
        .err     (err)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_onehot
        assign sel_onehot[s] = (code == CODE_W'(s + 1));
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == 1'b0) begin
            rd_data[CODE_W-1:0] = code;
        end else begin
            rd_data[0]       = busy;
            rd_data[ERR_BIT] = err;
        end
    end

    // R2: exactly one source is selected
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_onehot) == 1);

    // R7: a select write during a switch raises the error flag
    a_r7_busy_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && busy) |=> err);

    // R6: the one-hot output holds while a switch is settling
    a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(sel_onehot));

endmodule

// File: tb/tb_sd_clk_src_sel.sv
`timescale 1ns/1ps
module tb_sd_clk_src_sel;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic [2:0]  sel_onehot;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sd_clk_src_sel #(.SWITCH_CYCLES(N)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sel_onehot(sel_onehot), .busy(busy)
    );

    // behavioural reference model
    int m_code = 1, m_pend = 1, m_cnt = 0, m_err = 0;
    bit m_busy = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 1; m_pend = 1; m_cnt = 0; m_err = 0; m_busy = 0;
        end else begin
            bit was_busy;
            was_busy = m_busy;
            if (wr_en && !wr_addr) begin
                if (was_busy) m_err = 1;
                else begin
                    int msk, req;
                    msk = wr_data[17:16];
                    req = (m_code & ~msk & 3) | (int'(wr_data[1:0]) & msk);
                    if (req != m_code) begin
                        if (req == 0 || (m_code == 1 && req == 2) || (m_code == 2 && req == 1))
                            m_err = 1;
                        else begin
                            m_busy = 1; m_cnt = N; m_pend = req;
                        end
                    end
                end
            end
            if (wr_en && wr_addr && wr_data[1] && wr_data[17]) m_err = 0;
            if (was_busy) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin m_code = m_pend; m_busy = 0; end
            end
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(sel_onehot, 1 << (m_code - 1), "R2 onehot vs model");
            chk(busy, m_busy, "R6 busy vs model");
            if (rd_addr) chk(rd_data, (m_err << 1) | m_busy, "R8 status vs model");
            else chk(rd_data, m_code, "R2 select read vs model");
        end
    end

    task automatic wr(input bit a, input logic [31:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input bit a, output int v);
        rd_addr = a; #1; v = rd_data;
    endtask

    task automatic wait_idle();
        while (busy) begin @(posedge clk); #2; end
    endtask

    task automatic clear_err();
        wr(1'b1, 32'h0002_0002);
    endtask

    initial begin
        int v, cyc;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(sel_onehot, 3'b001, "R1 onehot after reset");
        chk(busy, 0, "R1 busy after reset");
        rd(1'b0, v); chk(v, 1, "R1 code after reset");
        rd(1'b1, v); chk(v, 0, "R1 status after reset");

        // R6 legal 1 -> 3, busy length
        wr(1'b0, 32'h0003_0003);
        chk(busy, 1, "R6 busy after legal write");
        chk(sel_onehot, 3'b001, "R6 onehot held while busy");
        cyc = 0;
        while (busy) begin @(posedge clk); #2; cyc++; end
        chk(cyc, N, "R6 busy cycle count");
        chk(sel_onehot, 3'b100, "R2 onehot for code 3");
        rd(1'b0, v); chk(v, 3, "R2 select read code 3");

        // 3 -> 2 legal
        wr(1'b0, 32'h0003_0002); wait_idle();
        chk(sel_onehot, 3'b010, "R2 onehot for code 2");

        // R5 direct 2 -> 1
        wr(1'b0, 32'h0003_0001); #1;
        chk(busy, 0, "R5 no switch on direct request");
        rd(1'b1, v); chk(v, 2, "R5 error flag set");
        rd(1'b0, v); chk(v, 2, "R5 code unchanged");

        // R8 clear without enable bit keeps flag, then real clear
        wr(1'b1, 32'h0000_0002);
        rd(1'b1, v); chk(v, 2, "R8 clear without mask ignored");
        clear_err();
        rd(1'b1, v); chk(v, 0, "R8 error cleared");

        // R4 code 0
        wr(1'b0, 32'h0003_0000); #1;
        chk(busy, 0, "R4 no switch on code 0");
        rd(1'b1, v); chk(v, 2, "R4 error flag set");
        rd(1'b0, v); chk(v, 2, "R4 code unchanged");
        clear_err();

        // R3 masked merge: current 2, enable bit0 only, value 1 -> 3
        wr(1'b0, 32'h0001_0003); wait_idle();
        rd(1'b0, v); chk(v, 3, "R3 masked merge gives code 3");
        // R3 zero mask: no-op, no error
        wr(1'b0, 32'h0000_0002); #1;
        chk(busy, 0, "R3 zero mask no switch");
        rd(1'b1, v); chk(v, 0, "R3 zero mask no error");
        // R3 enable bit1 only, value 0 -> code 1
        wr(1'b0, 32'h0002_0000); wait_idle();
        rd(1'b0, v); chk(v, 1, "R3 masked merge gives code 1");

        // R7 write during busy, then on the last busy cycle
        wr(1'b0, 32'h0003_0003);
        wr(1'b0, 32'h0003_0001);
        rd(1'b1, v); chk(v, 3, "R7 busy write rejected, error set");
        clear_err();
        wait_idle();
        rd(1'b0, v); chk(v, 3, "R7 running switch completed");
        wr(1'b0, 32'h0003_0002);
        repeat (N - 2) @(posedge clk);
        wr(1'b0, 32'h0003_0001);
        #1;
        chk(busy, 0, "R7 switch ended on collision edge");
        rd(1'b0, v); chk(v, 2, "R7 pending code applied at collision");
        rd(1'b1, v); chk(v, 2, "R7 last-cycle write rejected");
        wr(1'b0, 32'h0003_0003); #1;
        chk(busy, 1, "R7 retry accepted after switch");
        wait_idle();
        chk(sel_onehot, 3'b100, "R7 retry applied");

        repeat (3) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule